// File: doc/BRIEF.md
# Supply Low-Voltage Status Monitor

This block watches a supply rail through two digitized comparator outputs. One reports that the rail has dropped under the assert threshold. The other reports that the rail has climbed over the higher release threshold. From these two inputs the block keeps a sticky low-voltage status bit with hysteresis. The status goes to 1 on the lower crossing and returns to 0 only on the upper crossing. While the rail sits between the thresholds, the status does not move.

Every change of the status, in either direction, latches an interrupt flag. The interrupt output is that flag gated by a software enable bit.

Monitoring happens only while the mode-active input is high. At all other times the status is frozen. Software reaches the block through a small register port. It can write the enable, read the status and flag, and clear the flag by writing 1 to its bit.

Top module: `lvmon_top`

## Requirements
- R1: After reset, the status, the flag, the enable and `irq` are all 0.
- R2: Each comparator input passes through a two-flop synchronizer. A comparator change driven before a rising edge can first change the status on the third rising edge.
- R3: While `mode_active` is 1, an asserted `cmp_below` sets the status to 1.
- R4: While `mode_active` is 1, `cmp_above` alone clears the status to 0. With neither input asserted, the status keeps its value.
- R5: When both comparator inputs are asserted, the assert condition wins and the status becomes 1.
- R6: While `mode_active` is 0, the status holds its value whatever the comparator inputs do.
- R7: Any change of the status, 0 to 1 or 1 to 0, sets the flag on the same clock edge as the status change.
- R8: The flag is bit 1 at address 1 and is cleared by writing 1 to that bit. Writing 0 to bit 1 leaves the flag unchanged. The status (bit 0 at address 1) is read-only and writes to it are ignored.
- R9: If a status change and a flag clear fall on the same clock edge, the flag stays 1.
- R10: The enable is bit 0 at address 0, and it can be written and read back. `irq` is 1 exactly when both the flag and the enable are 1.
- R11: Reads are combinational from `reg_addr`. Address 1 returns the status in bit 0 and the flag in bit 1. Address 0 returns the enable in bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_active | input | 1 | Monitoring is allowed while this is 1 |
| cmp_below | input | 1 | Comparator output: supply is under the assert level |
| cmp_above | input | 1 | Comparator output: supply is over the release level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets four corner cases:

- **Both comparators asserted at once.** A design that let the release input win would clear the status instead of setting it.
- **The mid band between thresholds.** A design without hysteresis would drop the status as soon as the assert input falls.
- **A clear written on the very edge where the status changes.** A design that gave the clear priority would lose the event.
- **Toggling the mode input while the comparators move.** A design that kept monitoring would change the status with the mode off.

The bench also samples the status one edge before and on the edge where it is due. This catches a synchronizer with the wrong number of stages. Writes of 0 to the flag and of 1 to the read-only status bit must leave both bits unchanged.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
   localparam int CTRL_ADDR = 0;
   localparam int STAT_ADDR = 1;
   localparam int EN_BIT    = 0;
   localparam int LVS_BIT   = 0;
   localparam int FLAG_BIT  = 1;

   typedef struct packed {
      logic below;
      logic above;
   } cmp_pair_t;
endpackage

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lvmon_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lvmon_sync: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lvmon_hyst.sv
module lvmon_hyst
   import lvmon_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active,
   input  cmp_pair_t cmp,
   output logic      status,
   output logic      change
);
   logic status_q;
   logic status_nxt;

   always_comb begin
      status_nxt = status_q;
      if (active) begin
         if (cmp.below)      status_nxt = 1'b1;
         else if (cmp.above) status_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= 1'b0;
      else        status_q <= status_nxt;
   end

   assign status = status_q;
   assign change = status_nxt ^ status_q;

   // R3
   low_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && cmp.below |=> status_q);
   // R4
   high_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && !cmp.below && cmp.above |=> !status_q);
   // R5
   both_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && cmp.below && cmp.above |=> status_q);
   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(status_q));
endmodule

// File: rtl/lvmon_regs.sv
module lvmon_regs
   import lvmon_pkg::*;
#(
   parameter int ADDR_W = 1,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              status,
   input  logic              change,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int MIN_DATA_W = FLAG_BIT + 1;

   logic flag_q;
   logic en_q;
   logic sel_ctrl;
   logic sel_stat;
   logic clr;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_data
         $error("lvmon_regs: DATA_W too small for the register fields");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("lvmon_regs: ADDR_W must be at least 1");
      end
   endgenerate

   assign sel_ctrl = (reg_addr == ADDR_W'(CTRL_ADDR));
   assign sel_stat = (reg_addr == ADDR_W'(STAT_ADDR));
   assign clr      = reg_wr && sel_stat && reg_wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  en_q <= 1'b0;
      else if (reg_wr && sel_ctrl) en_q <= reg_wdata[EN_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (change) flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata[EN_BIT] = en_q;
      end else if (sel_stat) begin
         reg_rdata[LVS_BIT]  = status;
         reg_rdata[FLAG_BIT] = flag_q;
      end
   end

   assign irq = flag_q & en_q;

   // R7
   change_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      change |=> flag_q);
   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr |=> flag_q);
   // R9
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      change && clr |=> flag_q);
endmodule

// File: rtl/lvmon_top.sv
module lvmon_top
   import lvmon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 1,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_active,
   input  logic              cmp_below,
   input  logic              cmp_above,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int CMP_W = $bits(cmp_pair_t);

   cmp_pair_t raw_cmp;
   cmp_pair_t sync_cmp;
   logic      status;
   logic      change;

   assign raw_cmp.below = cmp_below;
   assign raw_cmp.above = cmp_above;

   lvmon_sync #(.STAGES(SYNC_STAGES), .WIDTH(CMP_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_cmp),
      .q     (sync_cmp)
   );

   lvmon_hyst u_hyst (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (mode_active),
      .cmp    (sync_cmp),
      .status (status),
      .change (change)
   );

   lvmon_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .status    (status),
      .change    (change),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );
endmodule

// File: tb/lvmon_top_bench.sv
module lvmon_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_active = 1'b0;
   logic       cmp_below = 1'b0;
   logic       cmp_above = 1'b0;
   logic       reg_wr = 1'b0;
   logic [0:0] reg_addr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;
   int         checks = 0;
   int         errors = 0;
   logic [7:0] rd;

   // vector: {mode, below, above, exp_status, exp_flag}
   localparam logic [4:0] VEC [12] = '{
      5'b10000, 5'b11011, 5'b10010, 5'b10101, 5'b10000, 5'b01000,
      5'b11011, 5'b00010, 5'b11110, 5'b10101, 5'b11111, 5'b10010
   };

   always #5 clk = ~clk;

   lvmon_top u_lvmon_top (
      .clk(clk), .rst_n(rst_n), .mode_active(mode_active),
      .cmp_below(cmp_below), .cmp_above(cmp_above), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #2;
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      #2;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #2;
      // R1 reset state
      rd_reg(1'b1, rd); chk("R1 status/flag", rd, 8'h00);
      rd_reg(1'b0, rd); chk("R1 enable", rd, 8'h00);
      chk("R1 irq", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); #2;
      wr_reg(1'b0, 8'h01);
      rd_reg(1'b0, rd); chk("R10 enable readback", rd, 8'h01);

      // R3 R4 R5 R6 R7 R11 vector walk
      for (int i = 0; i < 12; i++) begin
         mode_active = VEC[i][4];
         cmp_below   = VEC[i][3];
         cmp_above   = VEC[i][2];
         settle();
         rd_reg(1'b1, rd);
         chk("R3/R4/R5/R6 status", {7'b0, rd[0]}, {7'b0, VEC[i][1]});
         chk("R7 flag", {7'b0, rd[1]}, {7'b0, VEC[i][0]});
         chk("R11 unused bits", {2'b0, rd[7:2]}, 8'h00);
         chk("R10 irq", {7'b0, irq}, {7'b0, VEC[i][0]});
         wr_reg(1'b1, 8'h02);
      end

      // R2 synchronizer latency: status is 1 here, release now
      mode_active = 1'b1; cmp_below = 1'b0; cmp_above = 1'b1;
      repeat (2) @(posedge clk); #2;
      rd_reg(1'b1, rd); chk("R2 no change after two edges", rd, 8'h01);
      @(posedge clk); #2;
      rd_reg(1'b1, rd); chk("R2 change on third edge", rd, 8'h02);

      // R8 writing 0 to flag and 1 to status has no effect
      wr_reg(1'b1, 8'h01);
      rd_reg(1'b1, rd); chk("R8 ignored write", rd, 8'h02);

      // R10 gating by enable
      wr_reg(1'b0, 8'h00);
      chk("R10 irq masked", {7'b0, irq}, 8'h00);
      rd_reg(1'b0, rd); chk("R10 enable cleared", rd, 8'h00);
      wr_reg(1'b0, 8'h01);
      chk("R10 irq unmasked", {7'b0, irq}, 8'h01);

      // R9 clear on the same edge as a status change
      cmp_below = 1'b1; cmp_above = 1'b0;
      repeat (2) @(posedge clk); #2;
      wr_reg(1'b1, 8'h02);
      rd_reg(1'b1, rd); chk("R9 set beats clear", rd, 8'h03);

      // R8 plain clear
      wr_reg(1'b1, 8'h02);
      rd_reg(1'b1, rd); chk("R8 flag cleared", rd, 8'h01);
      chk("R10 irq drops", {7'b0, irq}, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule